// File: doc/BRIEF.md
# Step-Accumulating System Time Base with Three Alarms

This block keeps a 64-bit system time that advances by a programmable increment on every tick, not by one. Two 10-bit increments are held, one for the crystal clock source and one for the PLL source. A plain select input picks which increment is added. Software can overwrite the whole 64-bit time. It can also take a coherent copy of the time through a snapshot request: the copy is read as two 32-bit halves, and a valid flag marks when the copy is ready.

Three alarm units watch the time. Each unit works in one of two modes. In one-shot mode it fires once when the time reaches or passes an absolute 64-bit target. In periodic mode it fires at a fixed 30-bit interval, measured from the moment it was configured. Each fire sets a raw interrupt bit. Software clears the raw bit with a write, and it can mask the bit with an enable bit. A single interrupt line combines the enabled bits.

The block is accessed over a 32-bit register bus. Writes take effect on the clock edge. Reads are combinational on the word address. The register map is given in R3 to R10.

Top module: `stt_system_timer`

## Requirements
- R1: After reset, the following hold:
  - the time is 0;
  - the snapshot valid flag (address 5 bit 0) is 0;
  - raw interrupts (address 9) and `irq` are 0;
  - the control word (address 0) reads 0;
  - the step word (address 4) reads 0x450 (crystal step 80 in bits [9:0], PLL step 1 in bits [19:10]).
- R2: On each clock edge with `tick` high, the time increases, modulo 2^64, by the crystal step when `clk_sel` is 0 and by the PLL step when `clk_sel` is 1. With `tick` low the time holds.
- R3: Writing a word with bit 0 set to address 1 loads the time from the high holding word (address 2) and the low holding word (address 3). This load takes priority over a tick in the same cycle.
- R4: Writing bit 0 of address 5 requests a snapshot.
  - The valid flag reads 0 in the following cycle.
  - In the cycle after that, the flag reads 1, and addresses 6 (high) and 7 (low) hold the time as it stood in the cycle right after the request.
- R5: The control word at address 0 stores bit 0 (force clock) and bit 31 (register clock). Every other bit reads 0.
- R6: Alarm k (k = 0..2) uses three words, with base = 16 + 4k:
  - target high at base+0;
  - target low at base+1;
  - configuration at base+2, holding the period in bits [29:0], periodic mode in bit 30 and enable in bit 31.
  All three words read back what was written.
- R7: A one-shot alarm (enabled, bit 30 clear) fires once, when the time is greater than or equal to its target. Writing any of its three words re-arms it.
- R8: A write to a periodic alarm's configuration word sets its next fire time to the current time plus the period. The alarm fires when the time is greater than or equal to that next fire time. Each fire adds the period to the next fire time.
- R9: A fire of alarm k sets bit k of the raw word (address 9) on the following edge, whatever the state of its enable bit. Writing 1 to bit k of address 10 clears that raw bit, unless a fire happens in the same cycle.
- R10: `irq` is high exactly when some raw bit k and enable bit k (address 8) are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tick | input | 1 | Advance the time on this edge |
| clk_sel | input | 1 | Active source: 0 crystal step, 1 PLL step |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 5 | Word address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr` |
| irq | output | 1 | Combined enabled alarm interrupt |

## Verification
The assertions assume that each bus write lasts a single cycle and that software does not request a new snapshot in the cycle right after a request. The snapshot-ready property is conditioned on that second point. The stimulus drives every write for exactly one clock. It holds `tick` low during snapshot reads, keeps alarm targets and periods close to the current time so that fires actually happen, and mixes random clear writes with fires in the same cycle.

// File: rtl/stt_pkg.sv
package stt_pkg;
  // word addresses of the register bus
  localparam int A_CTRL   = 0;
  localparam int A_LOAD   = 1;
  localparam int A_LD_HI  = 2;
  localparam int A_LD_LO  = 3;
  localparam int A_STEP   = 4;
  localparam int A_SNAP   = 5;
  localparam int A_SN_HI  = 6;
  localparam int A_SN_LO  = 7;
  localparam int A_IEN    = 8;
  localparam int A_IRAW   = 9;
  localparam int A_ICLR   = 10;
  localparam int A_ALM_BASE   = 16;
  localparam int A_ALM_STRIDE = 4;
  localparam int OFS_TGT_HI   = 0;
  localparam int OFS_TGT_LO   = 1;
  localparam int OFS_CFG      = 2;
endpackage

// File: rtl/stt_rst_sync.sv
module stt_rst_sync (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);
  logic meta_q, sync_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign srst_n = sync_q;
endmodule

// File: rtl/stt_time_counter.sv
module stt_time_counter #(
  parameter int CNT_W  = 64,
  parameter int STEP_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_en,
  input  logic [CNT_W-1:0]  load_val,
  input  logic              tick,
  input  logic [STEP_W-1:0] step,
  output logic [CNT_W-1:0]  count
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_d  = cnt_q;
    cnt_en = load_en | tick;
    if (load_en)   cnt_d = load_val;
    else if (tick) cnt_d = cnt_q + CNT_W'(step);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign count = cnt_q;
endmodule

// File: rtl/stt_alarm.sv
module stt_alarm #(
  parameter int DATA_W = 32,
  parameter int PER_W  = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [2*DATA_W-1:0] count,
  input  logic [DATA_W-1:0]   wdata,
  input  logic                wr_hi,
  input  logic                wr_lo,
  input  logic                wr_cfg,
  output logic                hit,
  output logic [2*DATA_W-1:0] target_o,
  output logic [DATA_W-1:0]   cfg_o
);
  localparam int CNT_W   = 2 * DATA_W;
  localparam int PM_BIT  = DATA_W - 2;
  localparam int EN_BIT  = DATA_W - 1;

  logic [DATA_W-1:0] tgt_hi_q, tgt_lo_q;
  logic [PER_W-1:0]  per_q;
  logic              pm_q, en_q;
  logic [CNT_W-1:0]  next_q, next_d;
  logic              armed_q, armed_d;
  logic [CNT_W-1:0]  target;
  logic              reach;

  assign target = {tgt_hi_q, tgt_lo_q};

  always_comb begin
    reach = pm_q ? (count >= next_q) : (count >= target);
    hit   = en_q & armed_q & reach;
  end

  // next fire time and arming; a configuration write wins over a fire
  always_comb begin
    next_d  = next_q;
    armed_d = armed_q;
    if (hit) begin
      if (pm_q) next_d  = next_q + CNT_W'(per_q);
      else      armed_d = 1'b0;
    end
    if (wr_hi || wr_lo) armed_d = 1'b1;
    if (wr_cfg) begin
      armed_d = 1'b1;
      next_d  = count + CNT_W'(wdata[PER_W-1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_hi_q <= '0;
      tgt_lo_q <= '0;
      per_q    <= '0;
      pm_q     <= 1'b0;
      en_q     <= 1'b0;
      next_q   <= '0;
      armed_q  <= 1'b0;
    end else begin
      if (wr_hi) tgt_hi_q <= wdata;
      if (wr_lo) tgt_lo_q <= wdata;
      if (wr_cfg) begin
        per_q <= wdata[PER_W-1:0];
        pm_q  <= wdata[PM_BIT];
        en_q  <= wdata[EN_BIT];
      end
      next_q  <= next_d;
      armed_q <= armed_d;
    end
  end

  always_comb begin
    cfg_o              = '0;
    cfg_o[PER_W-1:0]   = per_q;
    cfg_o[PM_BIT]      = pm_q;
    cfg_o[EN_BIT]      = en_q;
  end

  assign target_o = target;
endmodule

// File: rtl/stt_system_timer.sv
module stt_system_timer
  import stt_pkg::*;
#(
  parameter int DATA_W        = 32,
  parameter int STEP_W        = 10,
  parameter int PER_W         = 30,
  parameter int NUM_ALARM     = 3,
  parameter int ADDR_W        = 5,
  parameter int XTAL_STEP_RST = 80,
  parameter int PLL_STEP_RST  = 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              clk_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  localparam int CNT_W = 2 * DATA_W;

  logic rst_sync_n;

  stt_rst_sync u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (rst_sync_n)
  );

  // write decode
  function automatic logic at(input int a);
    return bus_addr == ADDR_W'(a);
  endfunction

  logic ctrl_wr, load_wr, ldhi_wr, ldlo_wr, step_wr, snap_req, ien_wr, clr_wr;
  always_comb begin
    ctrl_wr  = bus_we & at(A_CTRL);
    load_wr  = bus_we & at(A_LOAD) & bus_wdata[0];
    ldhi_wr  = bus_we & at(A_LD_HI);
    ldlo_wr  = bus_we & at(A_LD_LO);
    step_wr  = bus_we & at(A_STEP);
    snap_req = bus_we & at(A_SNAP) & bus_wdata[0];
    ien_wr   = bus_we & at(A_IEN);
    clr_wr   = bus_we & at(A_ICLR);
  end

  // plain storage registers
  logic              ctrl_force_q, ctrl_regclk_q;
  logic [DATA_W-1:0] ld_hi_q, ld_lo_q;
  logic [STEP_W-1:0] step_xtal_q, step_pll_q;
  logic [NUM_ALARM-1:0] irq_en_q;

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      ctrl_force_q  <= 1'b0;
      ctrl_regclk_q <= 1'b0;
      ld_hi_q       <= '0;
      ld_lo_q       <= '0;
      step_xtal_q   <= STEP_W'(XTAL_STEP_RST);
      step_pll_q    <= STEP_W'(PLL_STEP_RST);
      irq_en_q      <= '0;
    end else begin
      if (ctrl_wr) begin
        ctrl_force_q  <= bus_wdata[0];
        ctrl_regclk_q <= bus_wdata[DATA_W-1];
      end
      if (ldhi_wr) ld_hi_q <= bus_wdata;
      if (ldlo_wr) ld_lo_q <= bus_wdata;
      if (step_wr) begin
        step_xtal_q <= bus_wdata[STEP_W-1:0];
        step_pll_q  <= bus_wdata[2*STEP_W-1:STEP_W];
      end
      if (ien_wr) irq_en_q <= bus_wdata[NUM_ALARM-1:0];
    end
  end

  // time counter
  logic [CNT_W-1:0]  count;
  logic [STEP_W-1:0] step_sel;
  assign step_sel = clk_sel ? step_pll_q : step_xtal_q;

  stt_time_counter #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (load_wr),
    .load_val ({ld_hi_q, ld_lo_q}),
    .tick     (tick),
    .step     (step_sel),
    .count    (count)
  );

  // snapshot path
  logic             snap_pend_q, snap_valid_q, snap_valid_d;
  logic [CNT_W-1:0] snap_q;

  always_comb begin
    snap_valid_d = snap_valid_q;
    if (snap_pend_q) snap_valid_d = 1'b1;
    if (snap_req)    snap_valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      snap_pend_q  <= 1'b0;
      snap_valid_q <= 1'b0;
      snap_q       <= '0;
    end else begin
      snap_pend_q  <= snap_req;
      snap_valid_q <= snap_valid_d;
      if (snap_pend_q) snap_q <= count;
    end
  end

  // alarm units
  logic [NUM_ALARM-1:0] alm_hit;
  logic [CNT_W-1:0]     alm_tgt [NUM_ALARM];
  logic [DATA_W-1:0]    alm_cfg [NUM_ALARM];

  for (genvar k = 0; k < NUM_ALARM; k++) begin : g_alarm
    localparam int BASE = A_ALM_BASE + A_ALM_STRIDE * k;
    stt_alarm #(.DATA_W(DATA_W), .PER_W(PER_W)) u_alarm (
      .clk      (clk),
      .rst_n    (rst_sync_n),
      .count    (count),
      .wdata    (bus_wdata),
      .wr_hi    (bus_we & at(BASE + OFS_TGT_HI)),
      .wr_lo    (bus_we & at(BASE + OFS_TGT_LO)),
      .wr_cfg   (bus_we & at(BASE + OFS_CFG)),
      .hit      (alm_hit[k]),
      .target_o (alm_tgt[k]),
      .cfg_o    (alm_cfg[k])
    );
  end

  // interrupt status; a fire wins over a clear in the same cycle
  logic [NUM_ALARM-1:0] irq_raw_q, irq_raw_d, clr_mask;
  always_comb begin
    clr_mask  = clr_wr ? bus_wdata[NUM_ALARM-1:0] : '0;
    irq_raw_d = alm_hit | (irq_raw_q & ~clr_mask);
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_raw_q <= '0;
    else             irq_raw_q <= irq_raw_d;
  end

  assign irq = |(irq_raw_q & irq_en_q);

  // read mux
  always_comb begin
    bus_rdata = '0;
    unique case (int'(bus_addr))
      A_CTRL: begin
        bus_rdata[0]        = ctrl_force_q;
        bus_rdata[DATA_W-1] = ctrl_regclk_q;
      end
      A_LD_HI: bus_rdata = ld_hi_q;
      A_LD_LO: bus_rdata = ld_lo_q;
      A_STEP:  bus_rdata[2*STEP_W-1:0] = {step_pll_q, step_xtal_q};
      A_SNAP:  bus_rdata[0] = snap_valid_q;
      A_SN_HI: bus_rdata = snap_q[CNT_W-1:DATA_W];
      A_SN_LO: bus_rdata = snap_q[DATA_W-1:0];
      A_IEN:   bus_rdata[NUM_ALARM-1:0] = irq_en_q;
      A_IRAW:  bus_rdata[NUM_ALARM-1:0] = irq_raw_q;
      default: bus_rdata = '0;
    endcase
    for (int k = 0; k < NUM_ALARM; k++) begin
      if (at(A_ALM_BASE + A_ALM_STRIDE * k + OFS_TGT_HI)) bus_rdata = alm_tgt[k][CNT_W-1:DATA_W];
      if (at(A_ALM_BASE + A_ALM_STRIDE * k + OFS_TGT_LO)) bus_rdata = alm_tgt[k][DATA_W-1:0];
      if (at(A_ALM_BASE + A_ALM_STRIDE * k + OFS_CFG))    bus_rdata = alm_cfg[k];
    end
  end
endmodule

// File: rtl/stt_system_timer_chk.sv
module stt_system_timer_chk #(
  parameter int CNT_W     = 64,
  parameter int NUM_ALARM = 3
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 tick,
  input logic                 load_wr,
  input logic [CNT_W-1:0]     load_val,
  input logic                 snap_req,
  input logic                 snap_valid,
  input logic [CNT_W-1:0]     count,
  input logic [NUM_ALARM-1:0] clr_mask,
  input logic [NUM_ALARM-1:0] hit,
  input logic [NUM_ALARM-1:0] raw
);
  // R2: no tick and no load keeps the time
  a_r2_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !load_wr) |=> $stable(count));

  // R3: a load places the holding words into the time
  a_r3_load: assert property (@(posedge clk) disable iff (!rst_n)
    load_wr |=> (count == $past(load_val)));

  // R4: the flag drops after a request and returns one cycle later
  a_r4_snap_drop: assert property (@(posedge clk) disable iff (!rst_n)
    snap_req |=> !snap_valid);

  a_r4_snap_ready: assert property (@(posedge clk) disable iff (!rst_n)
    (snap_req ##1 !snap_req) |=> snap_valid);

  for (genvar k = 0; k < NUM_ALARM; k++) begin : g_irq
    // R9: a fire sets the raw bit
    a_r9_fire_sets: assert property (@(posedge clk) disable iff (!rst_n)
      hit[k] |=> raw[k]);
    // R9: a raw bit only falls after a clear write
    a_r9_fall_needs_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(raw[k]) |-> $past(clr_mask[k]));
    // R9: a clear without a fire empties the bit
    a_r9_clear: assert property (@(posedge clk) disable iff (!rst_n)
      (clr_mask[k] && !hit[k]) |=> !raw[k]);
  end
endmodule

bind stt_system_timer stt_system_timer_chk #(.CNT_W(2 * DATA_W), .NUM_ALARM(NUM_ALARM)) u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .tick       (tick),
  .load_wr    (load_wr),
  .load_val   ({ld_hi_q, ld_lo_q}),
  .snap_req   (snap_req),
  .snap_valid (snap_valid_q),
  .count      (count),
  .clr_mask   (clr_mask),
  .hit        (alm_hit),
  .raw        (irq_raw_q)
);

// File: tb/test_stt_system_timer.sv
module test_stt_system_timer;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick = 1'b0;
  logic        clk_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [4:0]  bus_addr = 5'd9;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        irq;

  int vectors = 0;
  int miscompares = 0;
  bit mon_on = 1'b0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  stt_system_timer i_stt_system_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .clk_sel(clk_sel),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .irq(irq)
  );

  // reference model built from the requirements
  logic [63:0] m_cnt;
  logic [31:0] m_ldhi, m_ldlo;
  logic [9:0]  m_xs, m_ps;
  logic [2:0]  m_ien, m_raw;
  logic [31:0] m_thi [3];
  logic [31:0] m_tlo [3];
  logic [29:0] m_per [3];
  logic        m_pm [3];
  logic        m_aen [3];
  logic        m_arm [3];
  logic [63:0] m_nxt [3];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cnt = '0; m_ldhi = '0; m_ldlo = '0; m_xs = 10'd80; m_ps = 10'd1;
      m_ien = '0; m_raw = '0;
      for (int k = 0; k < 3; k++) begin
        m_thi[k] = '0; m_tlo[k] = '0; m_per[k] = '0; m_pm[k] = 1'b0;
        m_aen[k] = 1'b0; m_arm[k] = 1'b0; m_nxt[k] = '0;
      end
    end else begin
      logic [2:0] h;
      for (int k = 0; k < 3; k++)
        h[k] = m_aen[k] && m_arm[k] &&
               (m_pm[k] ? (m_cnt >= m_nxt[k]) : (m_cnt >= {m_thi[k], m_tlo[k]}));
      for (int k = 0; k < 3; k++) begin
        if (h[k]) m_raw[k] = 1'b1;
        else if (bus_we && bus_addr == 5'd10 && bus_wdata[k]) m_raw[k] = 1'b0;
        if (h[k]) begin
          if (m_pm[k]) m_nxt[k] = m_nxt[k] + 64'(m_per[k]);
          else         m_arm[k] = 1'b0;
        end
        if (bus_we && bus_addr == 5'(16 + 4*k)) begin m_thi[k] = bus_wdata; m_arm[k] = 1'b1; end
        if (bus_we && bus_addr == 5'(17 + 4*k)) begin m_tlo[k] = bus_wdata; m_arm[k] = 1'b1; end
        if (bus_we && bus_addr == 5'(18 + 4*k)) begin
          m_per[k] = bus_wdata[29:0]; m_pm[k] = bus_wdata[30]; m_aen[k] = bus_wdata[31];
          m_arm[k] = 1'b1; m_nxt[k] = m_cnt + 64'(bus_wdata[29:0]);
        end
      end
      if (bus_we && bus_addr == 5'd1 && bus_wdata[0]) m_cnt = {m_ldhi, m_ldlo};
      else if (tick) m_cnt = m_cnt + 64'(clk_sel ? m_ps : m_xs);
      if (bus_we && bus_addr == 5'd2) m_ldhi = bus_wdata;
      if (bus_we && bus_addr == 5'd3) m_ldlo = bus_wdata;
      if (bus_we && bus_addr == 5'd4) begin m_xs = bus_wdata[9:0]; m_ps = bus_wdata[19:10]; end
      if (bus_we && bus_addr == 5'd8) m_ien = bus_wdata[2:0];
    end
  end

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // per-cycle monitor, away from the active edge: R9 raw word and R10 irq
  always @(posedge clk) begin
    #3;
    if (mon_on) begin
      chk("R10 irq", 64'(irq), 64'(|(m_raw & m_ien)));
      if (!bus_we && bus_addr == 5'd9) chk("R9 raw", 64'(bus_rdata), 64'(m_raw));
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0; bus_addr = 5'd9;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
    bus_addr = 5'd9;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic run_ticks(input int n, input logic sel);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1; clk_sel = sel;
    end
    @(negedge clk); tick = 1'b0;
  endtask

  // R4 snapshot read with tick held low; returns the captured time
  task automatic snap(output logic [63:0] v);
    logic [31:0] d, hi, lo;
    logic [63:0] exp;
    tick = 1'b0;
    @(negedge clk);
    bus_we = 1'b1; bus_addr = 5'd5; bus_wdata = 32'd1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(5'd5, d);
    chk("R4 valid low after request", 64'(d[0]), 64'd0);
    exp = m_cnt;
    @(negedge clk);
    rd(5'd5, d);
    chk("R4 valid high", 64'(d[0]), 64'd1);
    rd(5'd6, hi);
    rd(5'd7, lo);
    v = {hi, lo};
    chk("R4 snapshot value", v, exp);
  endtask

  initial begin
    logic [31:0] d;
    logic [63:0] v;
    int r;
    r = $urandom(32'h5eed_0001);
    rst_n = 1'b0;
    idle(3);
    rst_n = 1'b1;
    idle(4);
    mon_on = 1'b1;

    // R1 reset state
    rd(5'd0, d);  chk("R1 control", 64'(d), 64'd0);
    rd(5'd4, d);  chk("R1 step", 64'(d), 64'h450);
    rd(5'd5, d);  chk("R1 valid", 64'(d), 64'd0);
    rd(5'd9, d);  chk("R1 raw", 64'(d), 64'd0);
    chk("R1 irq", 64'(irq), 64'd0);
    snap(v);      chk("R1 time", v, 64'd0);

    // R2 both step sources
    run_ticks(5, 1'b0);
    run_ticks(3, 1'b1);
    snap(v);      chk("R2 step sources", v, 64'd403);

    // R3 load wins over tick, then R2 wrap
    wr(5'd2, 32'hFFFF_FFFF);
    wr(5'd3, 32'hFFFF_FFF0);
    @(negedge clk);
    tick = 1'b1; clk_sel = 1'b0; bus_we = 1'b1; bus_addr = 5'd1; bus_wdata = 32'd1;
    @(negedge clk);
    tick = 1'b0; bus_we = 1'b0; bus_addr = 5'd9;
    snap(v);      chk("R3 load priority", v, 64'hFFFF_FFFF_FFFF_FFF0);
    run_ticks(1, 1'b0);
    snap(v);      chk("R2 wrap", v, 64'h40);

    // R5 control word
    wr(5'd0, 32'hFFFF_FFFF);
    rd(5'd0, d);  chk("R5 control bits", 64'(d), 64'h8000_0001);

    // R6 readback, R7 one-shot fire and R10 enabled irq
    wr(5'd16, 32'd0);
    wr(5'd17, 32'h108);
    wr(5'd18, 32'h8000_0000);
    rd(5'd17, d); chk("R6 target low", 64'(d), 64'h108);
    rd(5'd18, d); chk("R6 config", 64'(d), 64'h8000_0000);
    wr(5'd8, 32'd1);
    run_ticks(4, 1'b0);
    idle(2);
    rd(5'd9, d);  chk("R7 one-shot fired", 64'(d[0]), 64'd1);
    chk("R10 irq enabled", 64'(irq), 64'd1);
    wr(5'd10, 32'd1);
    idle(1);
    rd(5'd9, d);  chk("R9 cleared", 64'(d[0]), 64'd0);
    run_ticks(5, 1'b0);
    idle(2);
    rd(5'd9, d);  chk("R7 no second fire", 64'(d[0]), 64'd0);

    // R8 periodic with step 10; R9 raw set while masked, R10 irq low
    wr(5'd4, (32'd1 << 10) | 32'd10);
    wr(5'd22, 32'hC000_0000 | 32'd100);
    rd(5'd22, d); chk("R6 periodic config", 64'(d), 64'(32'hC000_0064));
    run_ticks(9, 1'b0);
    idle(2);
    rd(5'd9, d);  chk("R8 not yet", 64'(d[1]), 64'd0);
    run_ticks(1, 1'b0);
    idle(2);
    rd(5'd9, d);  chk("R8 first period", 64'(d[1]), 64'd1);
    chk("R10 masked", 64'(irq), 64'd0);
    wr(5'd10, 32'd2);
    run_ticks(10, 1'b0);
    idle(2);
    rd(5'd9, d);  chk("R8 second period", 64'(d[1]), 64'd1);

    // constrained random phase against the model
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      bus_we = 1'b0; bus_addr = 5'd9;
      tick = ($urandom % 4) != 0;
      clk_sel = 1'($urandom % 2);
      r = int'($urandom % 24);
      if (r < 10) begin
        int k;
        k = int'($urandom % 3);
        bus_we = 1'b1;
        case (r)
          0: begin bus_addr = 5'd4; bus_wdata = $urandom & 32'hF_FFFF; end
          1: begin bus_addr = 5'd10; bus_wdata = $urandom & 32'h7; end
          2: begin bus_addr = 5'd8; bus_wdata = $urandom & 32'h7; end
          3: begin bus_addr = 5'(18 + 4*k);
                   bus_wdata = {1'b1, 1'b1, 30'($urandom % 3000)}; end
          4: begin bus_addr = 5'(18 + 4*k);
                   bus_wdata = {1'b1, 1'b0, 30'd0}; end
          5: begin bus_addr = 5'(17 + 4*k);
                   bus_wdata = m_cnt[31:0] + ($urandom % 4000); end
          6: begin bus_addr = 5'(16 + 4*k); bus_wdata = m_cnt[63:32]; end
          7: begin bus_addr = 5'd2; bus_wdata = $urandom % 4; end
          8: begin bus_addr = 5'd3; bus_wdata = $urandom; end
          default: begin bus_addr = 5'd1; bus_wdata = 32'd1; end
        endcase
      end else if (r == 10) begin
        snap(v);
      end
    end
    @(negedge clk);
    bus_we = 1'b0; tick = 1'b0;
    snap(v);
    idle(2);

    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1'b1;
      miscompares++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule